// File: doc/BRIEF.md
# I2C Controller Status Flag Register

This block keeps the eight status flags of an I2C controller. The bus engine sends it one-cycle event pulses. A start condition seen on the bus, a stop condition seen on the bus, a start generated by this node, a lost arbitration, the ninth-clock acknowledge sample, and the eighth SCL rising edge together with the received address byte all arrive this way. The CPU side supplies a release command, the controller enable level, a read strobe and a strobe for bit-manipulation writes aimed at other bits of the register.

Each flag has its own set and clear events. When a set and a clear for the same flag fall in the same cycle, the set takes effect. The one exception is master status: an arbitration loss always drives it to 0. The byte is registered. Every event shows up on `status` one clock after the edge that samples it, and `status` is read directly by the CPU bus logic.

Top module: `i2c_stat_reg`

## Requirements
- R1: After reset, `status` reads 00h. Bit order from MSB to LSB is: master, arbitration lost, extension code, address match, transmit mode, acknowledge, start seen, stop seen.
- R2: Bit 7 (master) is set by `start_gen`. It is cleared by `stop_det`, `rel` or a 1-to-0 change of `en`. A simultaneous `start_gen` beats those clears.
- R3: `arb_lost` sets bit 6 and forces bit 7 to 0, even when `start_gen` is high in the same cycle.
- R4: Bit 6 is cleared in the cycle after `rd_stb` or `bw_stb`, or on an enable fall. A simultaneous `arb_lost` keeps it set. The read strobe leaves every other bit unchanged.
- R5: Bit 5 is set when `edge8` is high and `rx_addr[7:4]` is 0000 or 1111. It is cleared by `start_det`, `stop_det`, `rel` or an enable fall. Any other upper nibble leaves it unchanged.
- R6: Bit 4 is set when `edge8` and `addr_hit` are both high. It has the same clear events as bit 5.
- R7: Bit 3 is `tx_mode` registered while `en` is 1, and 0 while `en` is 0.
- R8: On `ack_stb`, bit 2 takes the inverse of `sda` (low SDA means acknowledged). It is cleared by `start_det`, `stop_det` or an enable fall.
- R9: Bit 1 is set by `start_det` and cleared by `stop_det` or an enable fall. Bit 0 is set by `stop_det` and cleared by `start_det` or an enable fall. For each bit, its set beats its clears.
- R10: A 1-to-0 change of `en` clears every flag in the following cycle, unless a set event for that flag is present in the same cycle. A steady low `en` does not clear the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Controller enable level |
| start_det | input | 1 | Start condition detected pulse |
| stop_det | input | 1 | Stop condition detected pulse |
| start_gen | input | 1 | This node generated a start pulse |
| arb_lost | input | 1 | Arbitration lost pulse |
| edge8 | input | 1 | Eighth SCL rising edge pulse |
| rx_addr | input | ADDR_W | Received address byte, valid with edge8 |
| addr_hit | input | 1 | Own address matched, valid with edge8 |
| ack_stb | input | 1 | Ninth-clock SDA sample strobe |
| sda | input | 1 | SDA level sampled with ack_stb |
| tx_mode | input | 1 | Transmit mode level from the bus engine |
| rel | input | 1 | Release command pulse |
| rd_stb | input | 1 | CPU read strobe for the status byte |
| bw_stb | input | 1 | CPU bit write to other bits of the register |
| status | output | 8 | Status byte |

## Verification
Every flag update lands exactly one clock after the rising edge that samples the event, and this includes the enable-fall clear, because the fall is found by comparing `en` with its registered copy. The bench drives its inputs on the falling edge. Before the next rising edge it computes the expected byte from the requirements, and it compares that byte at the falling edge that follows. Each check therefore covers exactly one register stage. Directed cases cover set/clear collisions, the extension-code nibbles, and read-clear with and without a competing arbitration loss. Random cycles fill in the rest.

// File: rtl/i2c_stat_reg.sv
module i2c_stat_reg #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              start_gen,
  input  logic              arb_lost,
  input  logic              edge8,
  input  logic [ADDR_W-1:0] rx_addr,
  input  logic              addr_hit,
  input  logic              ack_stb,
  input  logic              sda,
  input  logic              tx_mode,
  input  logic              rel,
  input  logic              rd_stb,
  input  logic              bw_stb,
  output logic [7:0]        status
);
  localparam int HI = ADDR_W - 1;

  logic en_q;
  logic mst, ald, exc, coi, trc, ack, std, spd;

  wire dis      = en_q & ~en;
  wire bus_clr  = start_det | stop_det | rel | dis;
  wire ext_hit  = edge8 & ((rx_addr[HI -: 4] == 4'h0) | (rx_addr[HI -: 4] == 4'hF));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      {mst, ald, exc, coi, trc, ack, std, spd} <= 8'h00;
    end else begin
      en_q <= en;

      if (arb_lost)                        mst <= 1'b0;
      else if (start_gen)                  mst <= 1'b1;
      else if (stop_det | rel | dis)       mst <= 1'b0;

      if (arb_lost)                        ald <= 1'b1;
      else if (rd_stb | bw_stb | dis)      ald <= 1'b0;

      if (ext_hit)                         exc <= 1'b1;
      else if (bus_clr)                    exc <= 1'b0;

      if (edge8 & addr_hit)                coi <= 1'b1;
      else if (bus_clr)                    coi <= 1'b0;

      trc <= en & tx_mode;

      if (ack_stb)                         ack <= ~sda;
      else if (start_det | stop_det | dis) ack <= 1'b0;

      if (start_det)                       std <= 1'b1;
      else if (stop_det | dis)             std <= 1'b0;

      if (stop_det)                        spd <= 1'b1;
      else if (start_det | dis)            spd <= 1'b0;
    end
  end

  assign status = {mst, ald, exc, coi, trc, ack, std, spd};

  AST_START_GEN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    start_gen && !arb_lost |=> status[7]); // R2
  AST_ARB_DROPS_MST: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |=> !status[7] && status[6]); // R3
  AST_ALD_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb || bw_stb) && !arb_lost |=> !status[6]); // R4
  AST_EXC_ONLY_EDGE8: assert property (@(posedge clk) disable iff (!rst_n)
    !edge8 |=> !$rose(status[5])); // R5
  AST_COI_ONLY_EDGE8: assert property (@(posedge clk) disable iff (!rst_n)
    !(edge8 && addr_hit) |=> !$rose(status[4])); // R6
  AST_TRC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !status[3]); // R7
  AST_ACK_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_stb |=> status[2] == !$past(sda)); // R8
  AST_START_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    start_det && !stop_det |=> status[1] && !status[0]); // R9
  AST_STOP_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det && !start_det |=> status[0] && !status[1]); // R9
  AST_DISABLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    en_q && !en && !start_det && !stop_det && !ack_stb |=> status[2:0] == 3'b000); // R10
endmodule

// File: tb/i2c_stat_reg_bench.sv
module i2c_stat_reg_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 0, start_det = 0, stop_det = 0, start_gen = 0, arb_lost = 0, edge8 = 0;
  logic [7:0] rx_addr = 8'h00;
  logic addr_hit = 0, ack_stb = 0, sda = 1, tx_mode = 0, rel = 0, rd_stb = 0, bw_stb = 0;
  logic [7:0] status;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_s = 8'h00;
  logic en_prev = 1'b0;
  bit done = 0;

  always #10 clk = ~clk;

  i2c_stat_reg #(.ADDR_W(8)) u_i2c_stat_reg (
    .clk(clk), .rst_n(rst_n), .en(en), .start_det(start_det), .stop_det(stop_det),
    .start_gen(start_gen), .arb_lost(arb_lost), .edge8(edge8), .rx_addr(rx_addr),
    .addr_hit(addr_hit), .ack_stb(ack_stb), .sda(sda), .tx_mode(tx_mode), .rel(rel),
    .rd_stb(rd_stb), .bw_stb(bw_stb), .status(status)
  );

  function automatic logic [7:0] next_status(logic [7:0] s, logic fall);
    logic [7:0] n;
    logic ext;
    n = s;
    ext = edge8 && (rx_addr[7:4] == 4'h0 || rx_addr[7:4] == 4'hF);
    // R2 / R3 master
    if (arb_lost) n[7] = 0; else if (start_gen) n[7] = 1; else if (stop_det || rel || fall) n[7] = 0;
    // R4 arbitration lost
    if (arb_lost) n[6] = 1; else if (rd_stb || bw_stb || fall) n[6] = 0;
    // R5 extension code
    if (ext) n[5] = 1; else if (start_det || stop_det || rel || fall) n[5] = 0;
    // R6 address match
    if (edge8 && addr_hit) n[4] = 1; else if (start_det || stop_det || rel || fall) n[4] = 0;
    // R7 transmit mode
    n[3] = en && tx_mode;
    // R8 acknowledge
    if (ack_stb) n[2] = !sda; else if (start_det || stop_det || fall) n[2] = 0;
    // R9 start/stop seen, R10 enable fall
    if (start_det) n[1] = 1; else if (stop_det || fall) n[1] = 0;
    if (stop_det) n[0] = 1; else if (start_det || fall) n[0] = 0;
    return n;
  endfunction

  task automatic check(string req);
    checks++;
    if (status !== exp_s) begin
      errors++;
      $display("FAIL %s: status=%02h expected=%02h", req, status, exp_s);
    end
  endtask

  task automatic quiet();
    start_det = 0; stop_det = 0; start_gen = 0; arb_lost = 0; edge8 = 0;
    addr_hit = 0; ack_stb = 0; rel = 0; rd_stb = 0; bw_stb = 0;
  endtask

  task automatic step(string req);
    exp_s = next_status(exp_s, en_prev && !en);
    en_prev = en;
    @(posedge clk);
    @(negedge clk);
    check(req);
    quiet();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: status=%02h expected=finish", status);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    exp_s = 8'h00;
    check("R1 reset");
    en = 1;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    en_prev = 1;
    check("R1 after reset");

    start_gen = 1; step("R2 start_gen sets master");
    start_gen = 1; stop_det = 1; step("R2 set beats stop clear");
    rel = 1; step("R2 release clears master");
    start_gen = 1; arb_lost = 1; step("R3 arb loss forces master low");
    rd_stb = 1; arb_lost = 1; step("R4 arb loss beats read clear");
    rd_stb = 1; step("R4 read clears arb lost");
    arb_lost = 1; step("R3 set arb lost");
    bw_stb = 1; step("R4 bit write clears arb lost");
    edge8 = 1; rx_addr = 8'h07; step("R5 nibble 0000 sets ext");
    start_det = 1; step("R5 start clears ext, R9 start seen");
    edge8 = 1; rx_addr = 8'hF8; addr_hit = 1; step("R5 nibble 1111, R6 match");
    edge8 = 1; rx_addr = 8'h70; step("R5 other nibble no change");
    rd_stb = 1; step("R4 read leaves other bits");
    ack_stb = 1; sda = 0; step("R8 ack captured");
    tx_mode = 1; step("R7 transmit mode");
    stop_det = 1; step("R9 stop seen, R5 R6 cleared");
    start_gen = 1; ack_stb = 1; sda = 0; step("R10 setup");
    en = 0; step("R10 enable fall clears");
    step("R10 steady low keeps");
    en = 1; start_gen = 1; step("R10 re-enable");
    en = 0; start_gen = 1; step("R10 set beats enable fall");
    en = 1; step("R10 enable back");

    for (int i = 0; i < 3000; i++) begin
      en        = ($urandom_range(0, 19) != 0);
      start_det = ($urandom_range(0, 7) == 0);
      stop_det  = ($urandom_range(0, 7) == 0);
      start_gen = ($urandom_range(0, 7) == 0);
      arb_lost  = ($urandom_range(0, 9) == 0);
      edge8     = ($urandom_range(0, 3) == 0);
      rx_addr   = 8'($urandom);
      if ($urandom_range(0, 2) == 0) rx_addr[7:4] = $urandom_range(0, 1) ? 4'hF : 4'h0;
      addr_hit  = $urandom_range(0, 1);
      ack_stb   = ($urandom_range(0, 5) == 0);
      sda       = $urandom_range(0, 1);
      tx_mode   = $urandom_range(0, 1);
      rel       = ($urandom_range(0, 9) == 0);
      rd_stb    = ($urandom_range(0, 5) == 0);
      bw_stb    = ($urandom_range(0, 11) == 0);
      step("R2-random R3 R4 R5 R6 R7 R8 R9 R10");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule